// File: doc/BRIEF.md
# Configurable TMDS Lane Serializer

This block turns a 30-bit parallel word of TMDS-encoded symbols into four serial lanes. The word arrives as three 10-bit groups: G0 in bits 9:0, G1 in bits 19:10 and G2 in bits 29:20. It is captured on the rising edge of the word clock `tmds_clk`. A bit clock `bit_clk` runs at exactly ten times the word rate with its rising edges aligned to the word clock. A symbol timer in the bit domain marks one bit-clock edge out of every ten as the word boundary. On that edge every lane reloads its shift register, and between boundaries it shifts one bit per bit clock, least significant bit first. A fourth source, the clock pattern, is low for serial bits 0 to 4 and high for bits 5 to 9. On any lane that carries it, the output falls at the start of every word.

A routing field gives each physical lane a 2-bit source select. A per-lane swap bit exchanges the two pads of the lane's differential pair. Both are sampled only on the word boundary. A routing in which two lanes pick the same source raises `map_invalid`.

Lane timing is set by reset release. The bench releases `rst_n` half a bit period after the bit-clock edge that follows a word-clock rising edge. The first boundary is then the next bit-clock edge, and every later boundary falls one bit period after a word-clock rising edge. A small state machine controls what the lanes send. It starts in `ST_HOLD`, where lanes are loaded with zeros and send a static low true level. It takes the transition `ST_HOLD -> ST_RUN` on the first boundary at which a captured word is present. It stays in `ST_RUN` until reset, and in that state every boundary loads the selected sources.

Top module: `tmds_lane_serializer`

## Requirements
- R1: `sym_in` is captured on each rising edge of `tmds_clk`. Group G0 is bits 9:0, G1 is bits 19:10 and G2 is bits 29:20.
- R2: The word captured at a word-clock edge is loaded on the word boundary one bit period later. During the bit period that starts at that load edge plus 4k ns, with k from 0 to 9, each lane sends bit k of its source. Bit 0 goes first and bit 9 last.
- R3: The clock-pattern source sends 0 for bits 0 to 4 and 1 for bits 5 to 9. On a lane that carries it across two words, the true level therefore falls at the start of each word.
- R4: Physical lane i takes its source select from `lane_map[2i+1:2i]`. Select values 0, 1 and 2 pick G0, G1 and G2, and value 3 picks the clock pattern.
- R5: When `lane_swap[i]` is 0, `pad_dx[i]` carries the true level and `pad_dy[i]` its complement. When the bit is 1, the two pads are exchanged.
- R6: During reset all `pad_dx` are 0, all `pad_dy` are 1 and `map_invalid` is 0. Until the first captured word is loaded (`ST_HOLD`), every lane, the clock lane included, sends true level 0 with the polarity latched on the boundary.
- R7: `map_invalid` is 1 exactly when two or more lanes hold equal select values. It is updated only on a word boundary, from the routing sampled there.
- R8: `lane_map` and `lane_swap` are sampled only on word boundaries. A change between boundaries has no effect on the word in flight.
- R9: For every lane, `pad_dy` is always the complement of `pad_dx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tmds_clk | input | 1 | Word-rate clock; `sym_in` is captured on its rising edge |
| bit_clk | input | 1 | Serial clock at ten times the word rate, edge-aligned to `tmds_clk` |
| rst_n | input | 1 | Asynchronous active-low reset for both clock domains |
| sym_in | input | 30 | Three 10-bit encoded symbols, G0 in the low bits |
| lane_map | input | 8 | 2-bit source select per physical lane, lane 0 in the low bits |
| lane_swap | input | 4 | Per-lane pad exchange |
| pad_dx | output | 4 | First pad of each lane's differential pair |
| pad_dy | output | 4 | Second pad of each lane's differential pair |
| map_invalid | output | 1 | Set when the routing sampled on the last boundary has a duplicate source |

## Verification
The bench builds the block with its default 10-bit symbols and three data groups, which gives four lanes and an 8-bit routing field. That small configuration lets it apply every one of the 256 routing values, each paired with its own swap pattern and its own data word. This covers all permutations, all duplicate routings and every lane carrying every source at both polarities. The bench changes the routing and swap half a word early, in the middle of the previous word's serial output. Every word therefore also shows that configuration takes effect only at the boundary. Each serial bit is predicted from the bit index, the group offset and the select value.

// File: rtl/tmds_ser_pkg.sv
package tmds_ser_pkg;

    // Serializer control: hold a static level until data exists, then run.
    typedef enum logic [0:0] {
        ST_HOLD = 1'b0,
        ST_RUN  = 1'b1
    } ser_state_e;

endpackage

// File: rtl/tmds_word_capture.sv
module tmds_word_capture #(
    parameter int SYM_W    = 10,
    parameter int NUM_DATA = 3
) (
    input  logic                        tmds_clk,
    input  logic                        rst_n,
    input  logic [NUM_DATA*SYM_W-1:0]   sym_in,
    output logic [NUM_DATA*SYM_W-1:0]   word_q,
    output logic                        word_vld
);

    // R1: parallel symbols registered on the word clock
    always_ff @(posedge tmds_clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q   <= '0;
            word_vld <= 1'b0;
        end else begin
            word_q   <= sym_in;
            word_vld <= 1'b1;
        end
    end

    // R6: once a word exists, the valid flag never drops until reset
    p_vld_sticky_r6: assert property (@(posedge tmds_clk) disable iff (!rst_n)
        $past(word_vld) |-> word_vld);

endmodule

// File: rtl/tmds_symbol_timer.sv
module tmds_symbol_timer #(
    parameter int SYM_W = 10
) (
    input  logic bit_clk,
    input  logic rst_n,
    output logic load
);

    localparam int CNT_W = $clog2(SYM_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign load = (cnt == '0);

    // R2: the counter never leaves its symbol range
    p_cnt_range_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        cnt <= LAST);

    // R2: boundaries are never back to back
    p_load_spacing_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        load |=> !load);

endmodule

// File: rtl/tmds_map_check.sv
module tmds_map_check #(
    parameter int NUM_LANES = 4,
    parameter int SEL_W     = 2
) (
    input  logic                        bit_clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic [NUM_LANES*SEL_W-1:0]  lane_map,
    output logic                        map_bad
);

    logic dup;

    always_comb begin
        dup = 1'b0;
        for (int a = 0; a < NUM_LANES; a++) begin
            for (int b = a + 1; b < NUM_LANES; b++) begin
                if (lane_map[a*SEL_W +: SEL_W] == lane_map[b*SEL_W +: SEL_W]) begin
                    dup = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            map_bad <= 1'b0;
        end else if (load) begin
            map_bad <= dup;
        end
    end

    // R7: the flag only moves on a word boundary
    p_flag_at_boundary_r7: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$past(load) |-> $stable(map_bad));

endmodule

// File: rtl/tmds_lane_shifter.sv
module tmds_lane_shifter #(
    parameter int SYM_W   = 10,
    parameter int NUM_SRC = 4,
    parameter int SEL_W   = 2
) (
    input  logic                        bit_clk,
    input  logic                        rst_n,
    input  logic                        load,
    input  logic                        take,
    input  logic [NUM_SRC*SYM_W-1:0]    src_words,
    input  logic [SEL_W-1:0]            sel_in,
    input  logic                        swap_in,
    output logic                        pad_dx,
    output logic                        pad_dy
);

    localparam logic [SEL_W-1:0] CLK_SEL = SEL_W'(NUM_SRC - 1);

    logic [SYM_W-1:0] sreg;
    logic [SYM_W-1:0] picked;
    logic [SEL_W-1:0] sel_q;
    logic             swap_q;
    logic             live_q;
    logic             true_bit;

    // R4: source selection without a variable part-select
    always_comb begin
        picked = '0;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (sel_in == SEL_W'(s)) begin
                picked = src_words[s*SYM_W +: SYM_W];
            end
        end
    end

    // R2 / R8: reload and config sample on the boundary, shift otherwise
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg   <= '0;
            sel_q  <= '0;
            swap_q <= 1'b0;
            live_q <= 1'b0;
        end else if (load) begin
            sreg   <= take ? picked : '0;
            sel_q  <= sel_in;
            swap_q <= swap_in;
            live_q <= take;
        end else begin
            sreg   <= {1'b0, sreg[SYM_W-1:1]};
        end
    end

    assign true_bit = sreg[0];
    // R5: pad polarity
    assign pad_dx   = true_bit ^ swap_q;
    assign pad_dy   = ~pad_dx;

    // R6: a lane that has not taken a word sends true level 0
    p_hold_low_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !live_q |-> ((pad_dx == swap_q) && (pad_dy != swap_q)));

    // R3: a live clock lane falls right after each boundary
    p_clk_fall_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        ($past(load) && live_q && $past(live_q) && (sel_q == CLK_SEL)
         && ($past(sel_q) == CLK_SEL)) |-> $fell(true_bit));

    // R9: the pair is always complementary
    p_pads_differ_r9: assert property (@(posedge bit_clk) disable iff (!rst_n)
        pad_dx != pad_dy);

    // R8: routing and polarity change only on a boundary
    p_cfg_boundary_r8: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(swap_q) && $stable(sel_q)));

endmodule

// File: rtl/tmds_lane_serializer.sv
module tmds_lane_serializer
    import tmds_ser_pkg::*;
#(
    parameter int SYM_W    = 10,
    parameter int NUM_DATA = 3
) (
    input  logic                                        tmds_clk,
    input  logic                                        bit_clk,
    input  logic                                        rst_n,
    input  logic [NUM_DATA*SYM_W-1:0]                   sym_in,
    input  logic [(NUM_DATA+1)*$clog2(NUM_DATA+1)-1:0]  lane_map,
    input  logic [NUM_DATA:0]                           lane_swap,
    output logic [NUM_DATA:0]                           pad_dx,
    output logic [NUM_DATA:0]                           pad_dy,
    output logic                                        map_invalid
);

    localparam int NUM_SRC   = NUM_DATA + 1;
    localparam int NUM_LANES = NUM_SRC;
    localparam int SEL_W     = $clog2(NUM_SRC);

    // R3: low for the first half of the word, high for the rest
    function automatic logic [SYM_W-1:0] clk_pattern();
        logic [SYM_W-1:0] p;
        for (int k = 0; k < SYM_W; k++) begin
            p[k] = (k >= SYM_W / 2);
        end
        return p;
    endfunction

    localparam logic [SYM_W-1:0] CLK_PAT = clk_pattern();

    logic [NUM_DATA*SYM_W-1:0] word_q;
    logic                      word_vld;
    logic                      load;
    logic                      take_word;
    logic [NUM_SRC*SYM_W-1:0]  src_words;
    ser_state_e                state, state_nx;

    tmds_word_capture #(
        .SYM_W    (SYM_W),
        .NUM_DATA (NUM_DATA)
    ) u_capture (
        .tmds_clk (tmds_clk),
        .rst_n    (rst_n),
        .sym_in   (sym_in),
        .word_q   (word_q),
        .word_vld (word_vld)
    );

    tmds_symbol_timer #(
        .SYM_W (SYM_W)
    ) u_timer (
        .bit_clk (bit_clk),
        .rst_n   (rst_n),
        .load    (load)
    );

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    // Next state: HOLD -> RUN on the first boundary with a captured word
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_HOLD: if (load && word_vld) state_nx = ST_RUN;
            ST_RUN:  state_nx = ST_RUN;
        endcase
    end

    // Outputs of the state machine
    always_comb begin
        take_word = 1'b0;
        unique case (state)
            ST_HOLD: take_word = load && word_vld;
            ST_RUN:  take_word = load;
        endcase
    end

    // R6: never enter RUN before the word domain holds data
    p_run_needs_word_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(state == ST_RUN) |-> $past(word_vld));

    assign src_words = {CLK_PAT, word_q};

    generate
        for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
            tmds_lane_shifter #(
                .SYM_W   (SYM_W),
                .NUM_SRC (NUM_SRC),
                .SEL_W   (SEL_W)
            ) u_lane (
                .bit_clk   (bit_clk),
                .rst_n     (rst_n),
                .load      (load),
                .take      (take_word),
                .src_words (src_words),
                .sel_in    (lane_map[i*SEL_W +: SEL_W]),
                .swap_in   (lane_swap[i]),
                .pad_dx    (pad_dx[i]),
                .pad_dy    (pad_dy[i])
            );
        end
    endgenerate

    tmds_map_check #(
        .NUM_LANES (NUM_LANES),
        .SEL_W     (SEL_W)
    ) u_map_check (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .load     (load),
        .lane_map (lane_map),
        .map_bad  (map_invalid)
    );

endmodule

// File: tb/tmds_lane_serializer_bench.sv
module tmds_lane_serializer_bench;

    localparam int NWORDS = 256;

    logic        tmds_clk;
    logic        bit_clk;
    logic        rst_n;
    logic [29:0] sym_in;
    logic [7:0]  lane_map;
    logic [3:0]  lane_swap;
    logic [3:0]  pad_dx;
    logic [3:0]  pad_dy;
    logic        map_invalid;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    tmds_lane_serializer u_tmds_lane_serializer (
        .tmds_clk    (tmds_clk),
        .bit_clk     (bit_clk),
        .rst_n       (rst_n),
        .sym_in      (sym_in),
        .lane_map    (lane_map),
        .lane_swap   (lane_swap),
        .pad_dx      (pad_dx),
        .pad_dy      (pad_dy),
        .map_invalid (map_invalid)
    );

    // 250 MHz bit clock, word clock at one tenth, rising edges together
    initial begin
        int hcnt;
        hcnt     = 0;
        bit_clk  = 1'b0;
        tmds_clk = 1'b0;
        forever begin
            #2;
            hcnt++;
            bit_clk = ~bit_clk;
            if (hcnt % 10 == 1) tmds_clk = ~tmds_clk;
        end
    end

    function automatic logic [29:0] data_of(int w);
        logic [31:0] t;
        t = (32'(w) * 32'h2545F491) ^ (32'(w) << 11) ^ 32'h15A5A5A5;
        return t[29:0];
    endfunction

    function automatic logic [7:0] map_of(int w);
        return 8'(w);
    endfunction

    function automatic logic [3:0] swap_of(int w);
        return 4'(w * 5 + 3);
    endfunction

    function automatic logic dup_of(logic [7:0] m);
        logic d;
        d = 1'b0;
        for (int a = 0; a < 4; a++)
            for (int b = a + 1; b < 4; b++)
                if (m[a*2 +: 2] == m[b*2 +: 2]) d = 1'b1;
        return d;
    endfunction

    // Check all four lanes for serial bit k of word w
    task automatic check_bit(int w, int k, logic [29:0] dat, logic [7:0] mp,
                             logic [3:0] sw, bit live);
        for (int i = 0; i < 4; i++) begin
            int   sel;
            logic exp_true;
            logic exp_dx;
            sel = int'(mp[i*2 +: 2]);
            if (!live)         exp_true = 1'b0;
            else if (sel == 3) exp_true = (k >= 5);
            else               exp_true = dat[sel*10 + k];
            exp_dx = exp_true ^ sw[i];
            n_checks++;
            if (pad_dx[i] !== exp_dx) begin
                n_fails++;
                if (!live)
                    $display("FAIL R6 hold lane %0d bit %0d: pad_dx=%b expected %b",
                             i, k, pad_dx[i], exp_dx);
                else if (sel == 3)
                    $display("FAIL R3/R4/R5/R8 clock lane %0d word %0d bit %0d: pad_dx=%b expected %b",
                             i, w, k, pad_dx[i], exp_dx);
                else
                    $display("FAIL R1/R2/R4/R5/R8 lane %0d word %0d bit %0d: pad_dx=%b expected %b",
                             i, w, k, pad_dx[i], exp_dx);
            end
            n_checks++;
            if (pad_dy[i] !== ~exp_dx) begin
                n_fails++;
                $display("FAIL R9 lane %0d word %0d bit %0d: pad_dy=%b expected %b",
                         i, w, k, pad_dy[i], ~exp_dx);
            end
        end
    endtask

    task automatic check_flag(int w, logic exp);
        n_checks++;
        if (map_invalid !== exp) begin
            n_fails++;
            $display("FAIL R7 word %0d: map_invalid=%b expected %b", w, map_invalid, exp);
        end
    endtask

    initial begin
        rst_n     = 1'b0;
        sym_in    = '0;
        lane_map  = 8'hE4;
        lane_swap = 4'b0101;
        #60;
        // R6: reset state
        n_checks++;
        if (pad_dx !== 4'h0 || pad_dy !== 4'hF) begin
            n_fails++;
            $display("FAIL R6 reset: pad_dx=%h pad_dy=%h expected 0 f", pad_dx, pad_dy);
        end
        check_flag(-1, 1'b0);
        @(posedge tmds_clk);
        @(negedge bit_clk);
        rst_n = 1'b1;
        fork
            begin
                for (int w = 0; w < NWORDS; w++) begin
                    @(negedge tmds_clk);
                    sym_in    = data_of(w);
                    lane_map  = map_of(w);
                    lane_swap = swap_of(w);
                end
            end
            begin
                // R6: word before the first capture is static low
                for (int k = 0; k < 10; k++) begin
                    #4;
                    check_bit(-1, k, 30'h0, 8'hE4, 4'b0101, 1'b0);
                    if (k == 0) check_flag(-1, 1'b0);
                end
                for (int w = 0; w < NWORDS; w++) begin
                    for (int k = 0; k < 10; k++) begin
                        #4;
                        check_bit(w, k, data_of(w), map_of(w), swap_of(w), 1'b1);
                        if (k == 0) check_flag(w, dup_of(map_of(w)));
                    end
                end
            end
        join
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        #100000;
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule